// File: doc/BRIEF.md
# T1 Framing-Bit Error Counter

This block keeps a running count of individual errors seen in the framing bits of a received T1 stream. An upstream framer recovers each framing bit and presents it with a one-cycle strobe. With the strobe it also gives the frame number within the superframe and a flag that says whether frame sync is currently held. The block works out whether that frame carries a checked framing bit and which bit value the pattern expects there. When the received bit disagrees and sync is held, the count goes up by one.

Two framing formats are supported. In extended superframe mode only the framing-pattern bits are checked, and the data-link and CRC positions are skipped. In D4 mode the terminal framing bits are always checked. The signalling framing bits are checked only when an enable input is set. All mismatches go into one saturating 8-bit count. A host reads that count and clears it with a strobe. The block keeps no alignment state of its own, because the frame position is an input on every strobe.

Top module: `fbit_err_counter`

## Requirements
- R1: After reset the count `err_cnt` reads 0.
- R2: With `esf_mode`=1, a strobed bit at `frame_idx` 3, 7, 11, 15, 19, 23 (0-based) is compared with the expected values 0, 0, 1, 0, 1, 1 in that order. A mismatch raises the count by one on the clock edge that samples the strobe.
- R3: With `esf_mode`=1, a strobe at any other `frame_idx` value never changes the count, whatever `fs_chk_en` holds.
- R4: With `esf_mode`=0, a strobed bit at even `frame_idx` 0, 2, 4, 6, 8, 10 is compared with 1, 0, 1, 0, 1, 0. A mismatch adds one.
- R5: With `esf_mode`=0 and `fs_chk_en`=1, a strobed bit at odd `frame_idx` 1, 3, 5, 7, 9, 11 is compared with 0, 0, 1, 1, 1, 0. A mismatch adds to the same count. With `fs_chk_en`=0 those slots are not counted. A `frame_idx` of 12 or more is never counted in D4 mode.
- R6: One strobe adds at most 1. Cycles without a strobe leave the count unchanged.
- R7: The count stops at 255 and never wraps.
- R8: While `sync_ok`=0, no mismatch is counted.
- R9: `clr_stb` sets the count to 0 on the next edge. If a counted mismatch arrives in the same cycle, the count becomes 1.
- R10: A change of `esf_mode` or `fs_chk_en` leaves the count as it is. The new setting applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fbit_stb | input | 1 | One-cycle strobe marking a framing-bit slot |
| fbit_val | input | 1 | Received framing bit |
| frame_idx | input | 5 | Frame number within the superframe, 0-based |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 |
| fs_chk_en | input | 1 | In D4 mode, also check signalling framing bits |
| sync_ok | input | 1 | Frame sync currently held |
| clr_stb | input | 1 | Host read-and-clear strobe |
| err_cnt | output | 8 | Saturating framing-bit error count |

## Verification
A wrong slot decode or pattern lookup shows at `err_cnt` one clock after the strobe concerned. Depending on the fault, the count either rises on a slot that should be skipped or stays put on a real mismatch. The bench sweeps every frame index, both bit values and both sync states in every mode combination, so such a fault is localised to a single slot. A counter fault, such as wrapping, a lost clear or a double increment, shows within one edge of reaching 255 or of a clear. The bench drives the count to that point on purpose.

// File: rtl/fbit_err_pkg.sv
package fbit_err_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_FPS  = 2'd1,
    SLOT_FT   = 2'd2,
    SLOT_FS   = 2'd3
  } slot_kind_e;

  localparam int PAT_LEN = 6;
  localparam int POS_W   = 3;

  // Expected bits, leftmost first in the superframe.
  localparam logic [PAT_LEN-1:0] PAT_FPS = 6'b001011;
  localparam logic [PAT_LEN-1:0] PAT_FT  = 6'b101010;
  localparam logic [PAT_LEN-1:0] PAT_FS  = 6'b001110;

endpackage

// File: rtl/fbit_rst_sync.sv
module fbit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fbit_slot_decode.sv
module fbit_slot_decode
  import fbit_err_pkg::*;
#(
  parameter int FRM_W    = 5,
  parameter int ESF_FRMS = 24,
  parameter int D4_FRMS  = 12,
  parameter int ESF_STEP = 4
) (
  input  logic [FRM_W-1:0] frame_idx,
  input  logic             esf_mode,
  input  logic             fs_chk_en,
  output slot_kind_e       slot_kind,
  output logic [POS_W-1:0] slot_pos
);

  localparam int STEP_W = $clog2(ESF_STEP);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(ESF_STEP - 1);
  localparam logic [FRM_W-1:0] ESF_LIM = FRM_W'(ESF_FRMS);
  localparam logic [FRM_W-1:0] D4_LIM  = FRM_W'(D4_FRMS);

  logic esf_in_range;
  logic d4_in_range;
  logic esf_on_step;

  always_comb begin
    esf_in_range = (frame_idx < ESF_LIM);
    d4_in_range  = (frame_idx < D4_LIM);
    esf_on_step  = (frame_idx[STEP_W-1:0] == STEP_LAST);
  end

  always_comb begin
    slot_kind = SLOT_NONE;
    slot_pos  = '0;
    if (esf_mode) begin
      if (esf_in_range && esf_on_step) begin
        slot_kind = SLOT_FPS;
        slot_pos  = POS_W'(frame_idx >> STEP_W);
      end
    end else if (d4_in_range) begin
      slot_pos = POS_W'(frame_idx >> 1);
      if (!frame_idx[0]) begin
        slot_kind = SLOT_FT;
      end else if (fs_chk_en) begin
        slot_kind = SLOT_FS;
      end
    end
  end

endmodule

// File: rtl/fbit_pat_rom.sv
module fbit_pat_rom #(
  parameter int                 PAT_LEN = 6,
  parameter int                 POS_W   = 3,
  parameter logic [PAT_LEN-1:0] PAT     = '0
) (
  input  logic [POS_W-1:0] pos,
  output logic             exp_bit
);

  always_comb begin
    exp_bit = 1'b0;
    for (int i = 0; i < PAT_LEN; i++) begin
      if (pos == POS_W'(i)) begin
        exp_bit = PAT[PAT_LEN-1-i];
      end
    end
  end

endmodule

// File: rtl/fbit_sat_cnt.sv
module fbit_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             at_max;

  always_comb begin
    at_max  = (cnt_q == CNT_MAX);
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    if (clr) begin
      cnt_en  = 1'b1;
      cnt_nxt = inc ? CNT_ONE : '0;
    end else if (inc && !at_max) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/fbit_err_counter.sv
module fbit_err_counter
  import fbit_err_pkg::*;
#(
  parameter int FRM_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fbit_stb,
  input  logic             fbit_val,
  input  logic [FRM_W-1:0] frame_idx,
  input  logic             esf_mode,
  input  logic             fs_chk_en,
  input  logic             sync_ok,
  input  logic             clr_stb,
  output logic [CNT_W-1:0] err_cnt
);

  logic             rst_sync_n;
  slot_kind_e       slot_kind;
  logic [POS_W-1:0] slot_pos;
  logic [2:0]       pat_bits;
  logic             exp_bit;
  logic             err_hit;

  fbit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fbit_slot_decode #(
    .FRM_W    (FRM_W),
    .ESF_FRMS (4 * PAT_LEN),
    .D4_FRMS  (2 * PAT_LEN),
    .ESF_STEP (4)
  ) u_dec (
    .frame_idx (frame_idx),
    .esf_mode  (esf_mode),
    .fs_chk_en (fs_chk_en),
    .slot_kind (slot_kind),
    .slot_pos  (slot_pos)
  );

  for (genvar g = 0; g < 3; g++) begin : g_pat
    localparam logic [PAT_LEN-1:0] SEL_PAT =
      (g == 0) ? PAT_FPS : ((g == 1) ? PAT_FT : PAT_FS);
    fbit_pat_rom #(
      .PAT_LEN (PAT_LEN),
      .POS_W   (POS_W),
      .PAT     (SEL_PAT)
    ) u_rom (
      .pos     (slot_pos),
      .exp_bit (pat_bits[g])
    );
  end

  always_comb begin
    unique case (slot_kind)
      SLOT_FPS: exp_bit = pat_bits[0];
      SLOT_FT:  exp_bit = pat_bits[1];
      SLOT_FS:  exp_bit = pat_bits[2];
      default:  exp_bit = fbit_val;
    endcase
    err_hit = fbit_stb && sync_ok && (slot_kind != SLOT_NONE) && (fbit_val != exp_bit);
  end

  fbit_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (err_hit),
    .clr   (clr_stb),
    .cnt   (err_cnt)
  );

endmodule

// File: rtl/fbit_err_counter_chk.sv
module fbit_err_counter_chk #(
  parameter int FRM_W = 5,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fbit_stb,
  input logic [FRM_W-1:0] frame_idx,
  input logic             esf_mode,
  input logic             sync_ok,
  input logic             clr_stb,
  input logic [CNT_W-1:0] err_cnt
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !clr_stb |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !fbit_stb && !clr_stb |=> $stable(err_cnt));

  // R8
  no_sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !sync_ok && !clr_stb |=> $stable(err_cnt));

  // R3
  esf_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && esf_mode && (frame_idx[1:0] != 2'b11) && !clr_stb |=> $stable(err_cnt));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && (err_cnt == CMAX) && !clr_stb |=> err_cnt == CMAX);

  // R9
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && clr_stb |=> err_cnt <= CNT_W'(1));

endmodule

bind fbit_err_counter fbit_err_counter_chk #(.FRM_W(FRM_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fbit_stb  (fbit_stb),
  .frame_idx (frame_idx),
  .esf_mode  (esf_mode),
  .sync_ok   (sync_ok),
  .clr_stb   (clr_stb),
  .err_cnt   (err_cnt)
);

// File: tb/sim_fbit_err_counter.sv
`timescale 1ns/1ps
module sim_fbit_err_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fbit_stb = 1'b0;
  logic       fbit_val = 1'b0;
  logic [4:0] frame_idx = '0;
  logic       esf_mode = 1'b0;
  logic       fs_chk_en = 1'b0;
  logic       sync_ok = 1'b0;
  logic       clr_stb = 1'b0;
  logic [7:0] err_cnt;

  int n_chk = 0;
  int n_err = 0;
  int model = 0;

  always #10 clk = ~clk;

  fbit_err_counter u0 (
    .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .fbit_val(fbit_val),
    .frame_idx(frame_idx), .esf_mode(esf_mode), .fs_chk_en(fs_chk_en),
    .sync_ok(sync_ok), .clr_stb(clr_stb), .err_cnt(err_cnt)
  );

  // -1 when the slot is not checked, else the expected bit
  function automatic int want_bit(input logic esf, input logic fsen, input int idx);
    if (esf) begin
      case (idx)
        3: return 0;  7: return 0;  11: return 1;
        15: return 0; 19: return 1; 23: return 1;
        default: return -1;
      endcase
    end
    case (idx)
      0: return 1; 2: return 0; 4: return 1; 6: return 0; 8: return 1; 10: return 0;
      default: ;
    endcase
    if (!fsen) return -1;
    case (idx)
      1: return 0; 3: return 0; 5: return 1; 7: return 1; 9: return 1; 11: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input int expv);
    n_chk++;
    if (int'(err_cnt) != expv) begin
      n_err++;
      $display("FAIL %s: err_cnt=%0d expected=%0d", tag, err_cnt, expv);
    end
  endtask

  task automatic strobe(input logic v, input int idx, input logic sy, input logic clr);
    @(negedge clk);
    fbit_stb  = 1'b1;
    fbit_val  = v;
    frame_idx = 5'(idx);
    sync_ok   = sy;
    clr_stb   = clr;
    @(negedge clk);
    fbit_stb = 1'b0;
    clr_stb  = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    clr_stb = 1'b1;
    @(negedge clk);
    clr_stb = 1'b0;
    model = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: err_cnt=%0d expected=finished", err_cnt);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", 0);

    // Exhaustive sweep over modes, slots, bit values, sync
    for (int m = 0; m < 4; m++) begin
      esf_mode  = m[1];
      fs_chk_en = m[0];
      clear_only();
      check("R9 clear", 0);
      for (int idx = 0; idx < 32; idx++) begin
        for (int v = 0; v < 2; v++) begin
          for (int sy = 0; sy < 2; sy++) begin
            int e;
            string tag;
            e = want_bit(esf_mode, fs_chk_en, idx);
            if (sy != 0 && e >= 0 && v != e && model < 255) model++;
            if (sy == 0)       tag = "R8 no sync";
            else if (esf_mode) tag = (e < 0) ? "R3 esf skip" : "R2 esf fps";
            else if (e < 0)    tag = "R5 d4 skip";
            else               tag = (idx % 2 == 0) ? "R4 d4 ft" : "R5 d4 fs";
            strobe(v[0], idx, sy[0], 1'b0);
            check(tag, model);
          end
        end
      end
    end

    // R6 idle cycles
    repeat (5) @(negedge clk);
    check("R6 idle", model);

    // R7 saturation
    esf_mode = 1'b1;
    clear_only();
    for (int k = 0; k < 300; k++) begin
      strobe(1'b1, 3, 1'b1, 1'b0);
      if (model < 255) model++;
      if (k == 253 || k == 254 || k == 299) check("R7 saturate", model);
    end

    // R9 clear with simultaneous error
    strobe(1'b1, 3, 1'b1, 1'b1);
    model = 1;
    check("R9 clear with hit", 1);
    clear_only();
    check("R9 clear alone", 0);

    // R10 mode change
    esf_mode = 1'b0;
    fs_chk_en = 1'b0;
    strobe(1'b0, 0, 1'b1, 1'b0);
    check("R10 d4 hit", 1);
    @(negedge clk);
    esf_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 change keeps count", 1);
    strobe(1'b0, 0, 1'b1, 1'b0);
    check("R10 new mode skip", 1);
    strobe(1'b0, 11, 1'b1, 1'b0);
    check("R10 new mode hit", 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule